// File: doc/BRIEF.md
# Cross-Coil Gauge PWM Channel with Staged Duty Update

This block drives one cross-coil gauge. It produces one PWM waveform for the cosine coil and one for the sine coil, and routes them onto four output pins. Software writes two duty values and a control byte into a staging set of registers through a simple write port. The staged values have no effect on the outputs until software sets an update flag in the control byte. The block then copies the whole staging set into the live set at the next wrap of the internal free-running period counter. The copy covers both duties, the one-count extension bits and the pin-steering code.

The update flag stays set until the copy happens and then clears itself. Software can poll it on the `upd_busy_o` output. While the flag is set, the staging registers are locked and every write is dropped. Each coil can stretch its high time by one count, which lets a full-scale duty hold the pin high for the whole period. A 2-bit steering code selects which pin of each coil's pair carries that coil's waveform. The other pin of the pair is held low.

Top module: `meter_pwm_chan`

## Requirements
- R1: After reset the update flag reads 0 and all four pins are low, and they stay low until the first update completes.
- R2: A control write (select 2) takes bit 4 as the update flag, bit 3 as the cos extension, bit 2 as the sin extension and bits 1:0 as the steering code. Bits 7:5 of the written byte have no effect.
- R3: While the update flag is 0, writes with select 0 (cos duty) and select 1 (sin duty) are stored in staging, and the pins do not change.
- R4: When the update flag is 1, the clock edge at which the counter wraps from 255 to 0 copies both duties, both extension bits and the steering code into the live set. The new values govern the period that begins at count 0.
- R5: The update flag clears at that same edge, so `upd_busy_o` is 1 from the control write until the wrap edge and 0 afterwards.
- R6: While the update flag is 1, every write (duty or control) is ignored, including a second control write that sets the flag again.
- R7: A coil's waveform is high while the counter is less than its live duty.
- R8: With the coil's extension bit set, the waveform is also high when the counter equals the duty. Duty 255 then stays high for the whole period, and duty 0 gives a single high count at count 0.
- R9: The steering code maps {pin_o[0],pin_o[1],pin_o[2],pin_o[3]} as 00:(cos,0,sin,0), 01:(cos,0,0,sin), 10:(0,cos,0,sin), 11:(0,cos,sin,0).
- R10: Steering and extension changes written with the update flag at 0 do not reach the pins until a later update.
- R11: A write in the wrap cycle is dropped if an update is pending. If no update is pending, it is accepted, and an update armed there completes at the following wrap, 256 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | 0 cos duty, 1 sin duty, 2 control byte, 3 none |
| wr_data | input | 8 | Write data |
| upd_busy_o | output | 1 | Update flag: staged update pending |
| pin_o | output | 4 | Coil pins, bit 0 is pin 1 |

## Verification
A software write and the counter wrap can land in the same cycle. That is the one point where the write lock and the self-clearing update flag race. The bench steps to count 255 using its own model of the counter and issues a write in exactly that cycle. It does this once with an update pending and once with none. In the first case the write must vanish, which shows up as the old duty still on the pins. In the second case the flag must stay busy for one more full period and the old steering must persist until the next wrap.

// File: rtl/meter_pwm_pkg.sv
package meter_pwm_pkg;
    localparam int unsigned DUTY_W   = 8;
    localparam int unsigned UPD_BIT  = 4;
    localparam int unsigned EXTC_BIT = 3;
    localparam int unsigned EXTS_BIT = 2;
    localparam int unsigned PINS     = 4;

    typedef enum logic [1:0] {
        SEL_COS  = 2'd0,
        SEL_SIN  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        logic       ext_cos;
        logic       ext_sin;
        logic [1:0] steer;
    } mode_t;

    typedef struct packed {
        duty_t cos;
        duty_t sin;
        mode_t mode;
    } set_t;
endpackage

// File: rtl/meter_pwm_cnt.sv
module meter_pwm_cnt
    import meter_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output duty_t cnt_o,
    output logic  wrap_o
);
    duty_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q + duty_t'(1);
        wrap_o = &cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R4: the wrap cycle is followed by count zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/meter_pwm_stage.sv
module meter_pwm_stage
    import meter_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  duty_t       wr_data,
    input  logic        wrap_i,
    output logic        load_o,
    output set_t        stg_o,
    output logic        busy_o
);
    typedef struct packed {
        set_t stg;
        logic upd;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = st_q.upd & wrap_i;
        if (load_o) st_d.upd = 1'b0;
        if (wr_en && !st_q.upd) begin
            case (sel_e'(wr_sel))
                SEL_COS:  st_d.stg.cos = wr_data;
                SEL_SIN:  st_d.stg.sin = wr_data;
                SEL_CTRL: begin
                    st_d.stg.mode.ext_cos = wr_data[EXTC_BIT];
                    st_d.stg.mode.ext_sin = wr_data[EXTS_BIT];
                    st_d.stg.mode.steer   = wr_data[1:0];
                    st_d.upd              = wr_data[UPD_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stg_o  = st_q.stg;
    assign busy_o = st_q.upd;

    // R6: staging is frozen while an update is pending
    p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd && wr_en) |=> $stable(st_q.stg));
    // R5: the flag is gone after the wrap that consumed it
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.upd && wrap_i) |=> !st_q.upd);
endmodule

// File: rtl/meter_pwm_live.sv
module meter_pwm_live
    import meter_pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  set_t            stg_i,
    input  duty_t           cnt_i,
    output logic [PINS-1:0] pin_o
);
    set_t live_d, live_q;
    logic cos_hi, sin_hi, sin_far;

    always_comb begin
        live_d = load_i ? stg_i : live_q;
        cos_hi = (cnt_i < live_q.cos) ||
                 (live_q.mode.ext_cos && (cnt_i == live_q.cos));
        sin_hi = (cnt_i < live_q.sin) ||
                 (live_q.mode.ext_sin && (cnt_i == live_q.sin));
        sin_far = live_q.mode.steer[1] ^ live_q.mode.steer[0];
        pin_o[0] = cos_hi & ~live_q.mode.steer[1];
        pin_o[1] = cos_hi &  live_q.mode.steer[1];
        pin_o[2] = sin_hi & ~sin_far;
        pin_o[3] = sin_hi &  sin_far;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    // R10: live settings move only on an update
    p_live_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(live_q));
    // R4: an update copies the staging set
    p_live_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (live_q == $past(stg_i)));
endmodule

// File: rtl/meter_pwm_chan.sv
module meter_pwm_chan
    import meter_pwm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DUTY_W-1:0] wr_data,
    output logic            upd_busy_o,
    output logic [PINS-1:0] pin_o
);
    duty_t cnt;
    logic  wrap, load;
    set_t  stg;

    meter_pwm_cnt u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    meter_pwm_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .wrap_i  (wrap),
        .load_o  (load),
        .stg_o   (stg),
        .busy_o  (upd_busy_o)
    );

    meter_pwm_live u_live (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .stg_i  (stg),
        .cnt_i  (cnt),
        .pin_o  (pin_o)
    );

    // R9: each coil drives at most one pin of its pair
    p_pair_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_o[0] && pin_o[1]) && !(pin_o[2] && pin_o[3]));
endmodule

// File: tb/meter_pwm_chan_bench.sv
`timescale 1ns/1ps
module meter_pwm_chan_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       upd_busy_o;
    logic [3:0] pin_o;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R1";

    typedef struct {
        logic [3:0] pins;
        logic       busy;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    // bench model of the channel
    int   mcnt = 0;
    logic m_upd = 0;
    logic [7:0] g_cos = 0, g_sin = 0, l_cos = 0, l_sin = 0;
    logic g_ec = 0, g_es = 0, l_ec = 0, l_es = 0;
    logic [1:0] g_st = 0, l_st = 0;

    always #2 clk = ~clk;

    meter_pwm_chan u_meter_pwm_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_busy_o(upd_busy_o), .pin_o(pin_o)
    );

    function automatic logic [3:0] model_pins();
        logic ch, sh;
        ch = (mcnt < l_cos) || (l_ec && mcnt == int'(l_cos));
        sh = (mcnt < l_sin) || (l_es && mcnt == int'(l_sin));
        case (l_st)
            2'b00: return {1'b0, sh, 1'b0, ch};
            2'b01: return {sh, 1'b0, 1'b0, ch};
            2'b10: return {sh, 1'b0, ch, 1'b0};
            default: return {1'b0, sh, ch, 1'b0};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; m_upd = 0;
            g_cos = 0; g_sin = 0; l_cos = 0; l_sin = 0;
            g_ec = 0; g_es = 0; l_ec = 0; l_es = 0; g_st = 0; l_st = 0;
        end else begin
            logic was_upd;
            exp_t e;
            was_upd = m_upd;
            if (was_upd && mcnt == 255) begin
                l_cos = g_cos; l_sin = g_sin; l_ec = g_ec; l_es = g_es; l_st = g_st;
                m_upd = 0;
            end
            if (wr_en && !was_upd) begin
                case (wr_sel)
                    2'd0: g_cos = wr_data;
                    2'd1: g_sin = wr_data;
                    2'd2: begin
                        g_ec = wr_data[3]; g_es = wr_data[2];
                        g_st = wr_data[1:0]; m_upd = wr_data[4];
                    end
                    default: ;
                endcase
            end
            mcnt = (mcnt + 1) % 256;
            e.pins = model_pins();
            e.busy = m_upd;
            e.tag  = cur_tag;
            sbq.push_back(e);
        end
    end

    // monitor: compare each cycle's outputs away from the clock edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (pin_o !== e.pins || upd_busy_o !== e.busy) begin
                fails++;
                $display("FAIL %s: pins=%b busy=%b expected pins=%b busy=%b",
                         e.tag, pin_o, upd_busy_o, e.pins, e.busy);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic wait_cnt(input int v);
        while (mcnt != v) begin @(posedge clk); #1; end
    endtask

    task automatic wait_done();
        while (m_upd) begin @(posedge clk); #1; end
    endtask

    task automatic periods(input int n);
        repeat (n * 256) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: quiet after reset
        chk("R1", {3'b0, upd_busy_o, pin_o}, 8'h00);
        periods(1);
        chk("R1", {4'b0, pin_o}, 8'h00);

        // R3: staged duties invisible
        cur_tag = "R3";
        wr(2'd0, 8'd100);
        wr(2'd1, 8'd50);
        periods(1);
        chk("R3", {4'b0, pin_o}, 8'h00);

        // R4/R5: update with steering 00
        cur_tag = "R4";
        wr(2'd2, 8'h10);
        chk("R5", {7'b0, upd_busy_o}, 8'h01);
        wait_done();
        chk("R5", {7'b0, upd_busy_o}, 8'h00);
        cur_tag = "R7";
        wait_cnt(60);
        chk("R7", {4'b0, pin_o}, 8'h01);
        periods(2);

        // R6: writes while pending are ignored
        cur_tag = "R6";
        wr(2'd2, 8'h11);
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h12);
        wait_done();
        wait_cnt(90);
        chk("R6", {4'b0, pin_o}, 8'h01);
        periods(1);

        // R8: one-count extension at both ends of the range
        cur_tag = "R8";
        wr(2'd0, 8'd255);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h1E);
        wait_done();
        chk("R8", {4'b0, pin_o}, 8'h0A);
        wait_cnt(1);
        chk("R8", {4'b0, pin_o}, 8'h02);
        wait_cnt(255);
        chk("R8", {4'b0, pin_o}, 8'h02);
        periods(1);

        // R9: steering 11
        cur_tag = "R9";
        wr(2'd0, 8'd200);
        wr(2'd1, 8'd120);
        wr(2'd2, 8'h13);
        wait_done();
        wait_cnt(10);
        chk("R9", {4'b0, pin_o}, 8'h06);
        wait_cnt(130);
        chk("R9", {4'b0, pin_o}, 8'h02);

        // R10: mode change without the flag stays staged
        cur_tag = "R10";
        wr(2'd2, 8'h00);
        periods(1);
        wait_cnt(10);
        chk("R10", {4'b0, pin_o}, 8'h06);
        wr(2'd2, 8'h10);
        wait_done();
        wait_cnt(10);
        chk("R10", {4'b0, pin_o}, 8'h05);

        // R2: reserved bits ignored
        cur_tag = "R2";
        wr(2'd2, 8'hF5);
        wait_done();
        wait_cnt(120);
        chk("R2", {4'b0, pin_o}, 8'h09);
        periods(1);

        // R11: write in the wrap cycle
        cur_tag = "R11";
        wr(2'd2, 8'h10);
        wait_cnt(255);
        wr(2'd0, 8'd9);
        chk("R11", {7'b0, upd_busy_o}, 8'h00);
        wait_cnt(150);
        chk("R11", {4'b0, pin_o}, 8'h01);
        wait_cnt(255);
        wr(2'd2, 8'h12);
        chk("R11", {7'b0, upd_busy_o}, 8'h01);
        wait_cnt(10);
        chk("R11", {4'b0, pin_o}, 8'h05);
        wait_done();
        wait_cnt(10);
        chk("R11", {4'b0, pin_o}, 8'h0A);
        periods(1);

        @(negedge clk);
        finish_run();
    end
endmodule